// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Hardware Address Filter

This block receives asynchronous serial frames of eight or nine data bits and keeps the last accepted frame in a holding register. A shared multi-drop bus uses the ninth bit to tell address frames from data frames. With the filter armed, a node sees only address frames. Data frames meant for other nodes never raise its receive flag.

Software reads the holding register when the flag is set. If the address matches, it disarms the filter and receives the following data frames. It re-arms the filter once the transfer is over. The bit clock comes from outside as a tick at sixteen times the bit rate. The flag, the framing error and the sticky overrun error are the only status kept.

Top module: `uart_addr_rx`

## Requirements
- R1: Each bit lasts 16 ticks. The line must stay low for 8 ticks, counting the tick that first sees it low, or no frame begins; a shorter low pulse is rejected. Each later bit is sampled 16 ticks after the one before it. Bit 0 comes first.
- R2: With `nine_bit_mode` low, a frame has 8 data bits and then the stop bit. `rd_bit9` loads as 0, and `addr_det_en` has no effect.
- R3: With `nine_bit_mode` high, a ninth bit follows bit 7. It is stored in `rd_bit9` beside the 8-bit `rd_data`.
- R4: With both `nine_bit_mode` and `addr_det_en` high, a frame whose ninth bit is 1 is loaded and `rx_flag` is set. `rx_flag` only ever rises in the cycle after a frame completes.
- R5: With both `nine_bit_mode` and `addr_det_en` high, a frame whose ninth bit is 0 is dropped. `rd_data`, `rd_bit9`, `frame_err`, `rx_flag` and `overrun_err` all keep their values.
- R6: A `rd_strobe` pulse clears `rx_flag`. The held data stays unchanged until the next load.
- R7: A stop bit sampled as 0 sets `frame_err` when that frame is loaded. `frame_err` changes only on a load. After a low stop bit, the receiver waits for the line to go high before it looks for a new start bit.
- R8: A frame that would be loaded while `rx_flag` is still set raises `overrun_err` and is discarded. While `overrun_err` is set, no frame is loaded.
- R9: `overrun_err` is sticky. It is cleared only while `rx_en` is low.
- R10: While `rx_en` is low, the line is ignored, the receiver goes to idle, and no frame is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idles high |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receiver enable; low clears overrun |
| nine_bit_mode | input | 1 | Selects 9 data bits per frame |
| addr_det_en | input | 1 | Address filter; effective only in 9-bit mode |
| rd_strobe | input | 1 | Read pulse; clears the receive flag |
| rd_data | output | 8 | Held data byte |
| rd_bit9 | output | 1 | Held ninth bit |
| rx_flag | output | 1 | Holding register has unread data |
| frame_err | output | 1 | Stop bit of the held frame was low |
| overrun_err | output | 1 | Sticky overrun indication |

## Verification
The assertions assume three things. The mode inputs do not change while a frame is on the line. A read strobe never arrives in the cycle where a frame completes. The tick is a single-cycle pulse. The stimulus changes modes and toggles the enable only during idle gaps between frames. It issues reads only after a frame and its trailing idle bit time, and drives the tick as a pulse on every second clock. Random frames mix both widths, both filter settings, both ninth-bit values, occasional low stop bits and skipped reads that force overruns.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;

    parameter int DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              stop_ok;
    } rx_frame_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb pipe_d = din;
        end else begin : g_chain
            always_comb pipe_d = {pipe_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
    import uart_addr_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      line,
    input  logic      tick,
    input  logic      nine_bit,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CNT_W  = $clog2(OVERSAMPLE);
    localparam int HALF   = OVERSAMPLE / 2;
    localparam int IDX_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVERSAMPLE - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W:0]   shreg;
        logic              done;
        rx_frame_t         frame;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic [IDX_W-1:0] last_idx;
    logic             centre;

    always_comb begin
        last_idx = nine_bit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
        centre   = tick && (st_q.cnt == CNT_FULL);
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!enable) begin
            st_d.state = RX_IDLE;
            st_d.cnt   = '0;
            st_d.idx   = '0;
        end else begin
            unique case (st_q.state)
                RX_IDLE: begin
                    if (tick && !line) begin
                        st_d.state = RX_START;
                        st_d.cnt   = CNT_W'(1);
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (st_q.cnt == CNT_HALF) begin
                            st_d.cnt   = '0;
                            st_d.idx   = '0;
                            st_d.shreg = '0;
                            st_d.state = line ? RX_IDLE : RX_DATA;
                        end else begin
                            st_d.cnt = st_q.cnt + CNT_W'(1);
                        end
                    end
                end
                RX_DATA: begin
                    if (centre) begin
                        st_d.cnt = '0;
                        st_d.shreg[st_q.idx] = line;
                        if (st_q.idx == last_idx) st_d.state = RX_STOP;
                        else                      st_d.idx = st_q.idx + IDX_W'(1);
                    end else if (tick) begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                RX_STOP: begin
                    if (centre) begin
                        st_d.cnt           = '0;
                        st_d.done          = 1'b1;
                        st_d.frame.data    = st_q.shreg[DATA_W-1:0];
                        st_d.frame.bit9    = st_q.shreg[DATA_W];
                        st_d.frame.stop_ok = line;
                        st_d.state         = line ? RX_IDLE : RX_BREAK;
                    end else if (tick) begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                RX_BREAK: begin
                    if (line) st_d.state = RX_IDLE;
                end
                default: st_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign done  = st_q.done;
    assign frame = st_q.frame;
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_addr_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              nine_bit,
    input  logic              addr_det,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] data,
    output logic              bit9,
    output logic              flag,
    output logic              ferr,
    output logic              oerr
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              flag;
        logic              ferr;
        logic              oerr;
    } hold_st_t;

    hold_st_t hs_d, hs_q;
    logic kept, occupied;

    always_comb begin
        kept     = !(nine_bit && addr_det && !frame.bit9);
        occupied = hs_q.flag && !rd_strobe;
        hs_d     = hs_q;
        if (rd_strobe) hs_d.flag = 1'b0;
        if (!enable) begin
            hs_d.oerr = 1'b0;
        end else if (done && kept && !hs_q.oerr) begin
            if (occupied) begin
                hs_d.oerr = 1'b1;
            end else begin
                hs_d.data = frame.data;
                hs_d.bit9 = nine_bit && frame.bit9;
                hs_d.ferr = !frame.stop_ok;
                hs_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign data = hs_q.data;
    assign bit9 = hs_q.bit9;
    assign flag = hs_q.flag;
    assign ferr = hs_q.ferr;
    assign oerr = hs_q.oerr;
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_addr_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              nine_bit_mode,
    input  logic              addr_det_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rx_flag,
    output logic              frame_err,
    output logic              overrun_err
);
    logic      line_s;
    logic      frame_done_w;
    rx_frame_t frame_w;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    uart_rx_shifter #(.OVERSAMPLE(OVERSAMPLE)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (rx_en),
        .line    (line_s),
        .tick    (tick),
        .nine_bit(nine_bit_mode),
        .done    (frame_done_w),
        .frame   (frame_w)
    );

    uart_rx_hold i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (rx_en),
        .nine_bit (nine_bit_mode),
        .addr_det (addr_det_en),
        .done     (frame_done_w),
        .frame    (frame_w),
        .rd_strobe(rd_strobe),
        .data     (rd_data),
        .bit9     (rd_bit9),
        .flag     (rx_flag),
        .ferr     (frame_err),
        .oerr     (overrun_err)
    );
endmodule

// File: rtl/uart_addr_rx_checker.sv
module uart_addr_rx_checker
    import uart_addr_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              nine_bit_mode,
    input logic              addr_det_en,
    input logic              rd_strobe,
    input logic              frame_done,
    input logic              frame_bit9,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_bit9,
    input logic              rx_flag,
    input logic              frame_err,
    input logic              overrun_err
);
    assert_read_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !frame_done |=> !rx_flag);

    assert_held_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag && !rd_strobe |=> $stable(rd_data) && $stable(rd_bit9) && $stable(frame_err));

    assert_data_frame_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && nine_bit_mode && addr_det_en && !frame_bit9 && !rd_strobe
        |=> $stable(rx_flag) && $stable(rd_data) && $stable(overrun_err));

    assert_flag_after_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(frame_done));

    assert_eight_bit_no_ninth_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) && !nine_bit_mode |-> !rd_bit9);

    assert_overrun_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |=> $stable(rd_data) && $stable(frame_err));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err && rx_en |=> overrun_err);

    assert_overrun_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !overrun_err);
endmodule

bind uart_addr_rx uart_addr_rx_checker i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .nine_bit_mode(nine_bit_mode),
    .addr_det_en  (addr_det_en),
    .rd_strobe    (rd_strobe),
    .frame_done   (frame_done_w),
    .frame_bit9   (frame_w.bit9),
    .rd_data      (rd_data),
    .rd_bit9      (rd_bit9),
    .rx_flag      (rx_flag),
    .frame_err    (frame_err),
    .overrun_err  (overrun_err)
);

// File: tb/test_uart_addr_rx.sv
module test_uart_addr_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       addr_det_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rx_flag, frame_err, overrun_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_data = 8'h00;
    logic       exp_bit9 = 1'b0, exp_flag = 1'b0, exp_ferr = 1'b0, exp_oerr = 1'b0;

    always #2.5 clk = ~clk;

    uart_addr_rx i_uart_addr_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick(tick), .rx_en(rx_en),
        .nine_bit_mode(nine_bit_mode), .addr_det_en(addr_det_en), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rd_bit9(rd_bit9), .rx_flag(rx_flag),
        .frame_err(frame_err), .overrun_err(overrun_err)
    );

    initial begin
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " data"}, 32'(rd_data), 32'(exp_data));
        chk({req, " bit9"}, 32'(rd_bit9), 32'(exp_bit9));
        chk({req, " flag"}, 32'(rx_flag), 32'(exp_flag));
        chk({req, " ferr"}, 32'(frame_err), 32'(exp_ferr));
        chk({req, " oerr"}, 32'(overrun_err), 32'(exp_oerr));
    endtask

    task automatic wait_ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    function automatic logic frame_kept(input logic nine, input logic adr, input logic b9);
        return !(nine && adr && !b9);
    endfunction

    task automatic model_frame(input logic [7:0] d, input logic b9, input logic stop_v);
        if (!rx_en) return;
        if (!frame_kept(nine_bit_mode, addr_det_en, b9)) return;
        if (exp_oerr) return;
        if (exp_flag) begin
            exp_oerr = 1'b1;
        end else begin
            exp_data = d;
            exp_bit9 = nine_bit_mode && b9;
            exp_ferr = !stop_v;
            exp_flag = 1'b1;
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop_v);
        @(negedge clk);
        rx_line = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            wait_ticks(16);
        end
        if (nine_bit_mode) begin
            rx_line = b9;
            wait_ticks(16);
        end
        rx_line = stop_v;
        wait_ticks(16);
        rx_line = 1'b1;
        wait_ticks(16);
        model_frame(d, b9, stop_v);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        exp_flag = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_disable();
        @(negedge clk);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        exp_oerr = 1'b0;
        rx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("reset");

        rx_en = 1'b1;
        // R1 R2: plain 8-bit frame, LSB first
        send_frame(8'hA5, 1'b0, 1'b1);
        chk_all("R1 R2 8-bit frame");
        do_read();
        chk("R6 flag cleared", 32'(rx_flag), 32'd0);
        chk("R6 data kept", 32'(rd_data), 32'h0A5);

        // R2: filter ignored in 8-bit mode
        addr_det_en = 1'b1;
        send_frame(8'h3C, 1'b0, 1'b1);
        chk_all("R2 filter ignored");
        do_read();
        addr_det_en = 1'b0;

        // R3: ninth bit passed through
        nine_bit_mode = 1'b1;
        send_frame(8'h5A, 1'b1, 1'b1);
        chk_all("R3 ninth bit");
        do_read();

        // R5: data frame dropped with filter on
        addr_det_en = 1'b1;
        send_frame(8'hC3, 1'b0, 1'b1);
        chk_all("R5 data dropped");
        // R4: address frame accepted
        send_frame(8'h12, 1'b1, 1'b1);
        chk_all("R4 address accepted");
        do_read();
        addr_det_en = 1'b0;

        // R7: low stop bit
        send_frame(8'h77, 1'b0, 1'b0);
        chk_all("R7 framing error");
        do_read();
        send_frame(8'h66, 1'b1, 1'b1);
        chk_all("R7 framing error replaced");
        do_read();

        // R8: overrun
        send_frame(8'h01, 1'b0, 1'b1);
        send_frame(8'h02, 1'b0, 1'b1);
        chk_all("R8 overrun set");
        do_read();
        send_frame(8'h03, 1'b0, 1'b1);
        chk_all("R8 load blocked");
        // R9: cleared only by disable
        pulse_disable();
        chk_all("R9 overrun cleared");
        send_frame(8'h04, 1'b1, 1'b1);
        chk_all("R9 load after clear");
        do_read();

        // R10: disabled receiver ignores line
        rx_en = 1'b0;
        send_frame(8'h99, 1'b1, 1'b1);
        chk_all("R10 disabled ignores");
        rx_en = 1'b1;
        send_frame(8'h44, 1'b0, 1'b1);
        chk_all("R10 re-enabled");
        do_read();

        // R1: short low glitch rejected
        @(negedge clk);
        rx_line = 1'b0;
        wait_ticks(4);
        rx_line = 1'b1;
        wait_ticks(20);
        chk_all("R1 glitch rejected");
        send_frame(8'hE1, 1'b1, 1'b1);
        chk_all("R1 frame after glitch");
        do_read();

        // Random mix
        for (int n = 0; n < 150; n++) begin
            logic [7:0] d;
            logic       b9, sv;
            nine_bit_mode = 1'($urandom % 2);
            addr_det_en   = 1'($urandom % 2);
            d  = 8'($urandom);
            b9 = 1'($urandom % 2);
            sv = ($urandom % 10) != 0;
            if (($urandom % 15) == 0) pulse_disable();
            send_frame(d, b9, sv);
            chk_all("R4 R5 R8 random");
            if (($urandom % 2) == 0) do_read();
        end

        finish_run();
    end
endmodule